// File: doc/BRIEF.md
# Aliased-Register Interrupt Enable Unit

This block decides which of a small set of interrupt sources may reach the processor. A single source can be gated by several register fields at once: one-bit mask fields, multi-bit priority fields and a group enable bit. The source is released only when every field that references it is in its enabling state. Inside the block, each source holds a count of its currently enabling references. The source is enabled when that count reaches a per-source maximum, which is fixed by the field-to-source map.

Software programs the unit over a plain register bus with an address, a write strobe, write data and combinational read data. Each mask register has two addresses. A write to the set address turns bits on, and a write to the clear address turns bits off, so no read-modify-write sequence is needed. The priority register has one address and is overwritten directly.

The unit drives two results from its state. One is the enabled vector. The other is the vector code of the lowest-numbered source that is both enabled and pending, together with a valid flag.

Top module: `aenc_ctrl`

## Requirements
- R1: After reset every stored register reads 0, every enable count is 0, `src_en` is all zeros and `vec_valid` is low, even with all pending lines high.
- R2: Only address bits [28:0] are decoded. Writes and reads with any value in bits [31:29] reach the same register.
- R3: A write to a mask set address (mask 0 at 0x00, mask 1 at 0x08) ORs data bits [3:0] into the stored mask. Reading either of that register's two addresses returns the stored value.
- R4: A write to a mask clear address (mask 0 at 0x04, mask 1 at 0x0C) clears each stored bit whose data bit [3:0] is 1 and leaves the other bits unchanged.
- R5: A write to the priority address 0x10 replaces all 16 stored bits. A read of 0x10 returns them.
- R6: Field k of a mask register is bit 3-k. Field k of the priority register is bits [15-4k:12-4k], and it enables its source when nonzero. Mask 0 fields 0..3 feed sources 1, 2, 3 and 0. Mask 1 fields 0..3 feed sources 4, 5, 6 and 7. Priority fields 0..3 feed sources 1, 4, 5 and 0.
- R7: A source with a vector (ids 1 to 6) is enabled exactly when all of its referencing fields enable it. Its `src_en` bit changes in the cycle after the write and holds while no write occurs.
- R8: Id 0 is reserved. Changes to fields mapped to it (mask 0 bit 0, priority bits [3:0]) change no `src_en` bit.
- R9: Id 7 is a group with no vector. Its field (mask 1 bit 0) is an additional enable for members 5 and 6. Bit 7 of `src_en` stays 0.
- R10: `vec_valid` is high when any source is both pending and enabled. In the same cycle, `vec_code` is 0x400 + 0x20 * id of the lowest such id.
- R11: Writes to unmapped addresses change no register and no enable. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irq_pend | input | 8 | Pending line per source id |
| src_en | output | 8 | Enabled flag per source id |
| vec_valid | output | 1 | An enabled source is pending |
| vec_code | output | 12 | Vector code of the lowest enabled pending id |

## Verification
Vector selection and an enable update can land on the same cycle. This is provoked by holding sources 2 and 3 pending and enabled, then driving a clear-alias write that removes source 2's mask bit. Before the clock edge, the code must still name source 2. After the edge, it must name source 3. The sweep then walks every mask pair against eight priority patterns, reaching each state through set and clear writes, and judges `src_en` and the vector against a plain AND of the referencing fields.

// File: rtl/aenc_pkg.sv
package aenc_pkg;
    localparam int NSRC    = 8;
    localparam int SRC_W   = $clog2(NSRC);
    localparam int NMASK   = 2;
    localparam int MASK_W  = 4;
    localparam int PRIO_W  = 16;
    localparam int PFLD_W  = 4;
    localparam int NPFLD   = PRIO_W / PFLD_W;
    localparam int GRP_ID  = 7;
    localparam int NGMEM   = 2;
    localparam int CNT_W   = $clog2(NMASK + 3);
    localparam int VEC_BASE = 'h400;
    localparam int VEC_STEP = 'h20;
    localparam int PRIO_ADDR = 'h10;

    typedef logic [NMASK-1:0][MASK_W-1:0] mask_arr_t;
    typedef logic [NSRC-1:0][CNT_W-1:0]   cnt_arr_t;
    typedef logic [NSRC-1:0][CNT_W:0]     dlt_arr_t;

    typedef struct packed {
        mask_arr_t         mask;
        logic [PRIO_W-1:0] prio;
        cnt_arr_t          cnt;
    } st_t;

    // source id fed by field k of mask register r (field 0 = top bit)
    function automatic int mask_src(input int r, input int k);
        case (r * MASK_W + k)
            0: return 1;
            1: return 2;
            2: return 3;
            4: return 4;
            5: return 5;
            6: return 6;
            7: return 7;
            default: return 0;
        endcase
    endfunction

    function automatic int prio_src(input int k);
        case (k)
            0: return 1;
            1: return 4;
            2: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic int grp_mem(input int m);
        return (m == 0) ? 5 : 6;
    endfunction

    function automatic bit has_vec(input int id);
        return (id >= 1) && (id <= 6);
    endfunction

    function automatic int mask_set_addr(input int r);
        return r * 8;
    endfunction

    function automatic int mask_clr_addr(input int r);
        return r * 8 + 4;
    endfunction

    // number of fields and group entries that gate a source
    function automatic int src_max(input int id);
        int n;
        n = 0;
        for (int r = 0; r < NMASK; r++)
            for (int k = 0; k < MASK_W; k++)
                if (mask_src(r, k) == id) n++;
        for (int k = 0; k < NPFLD; k++)
            if (prio_src(k) == id) n++;
        for (int m = 0; m < NGMEM; m++)
            if (grp_mem(m) == id) n++;
        return n;
    endfunction
endpackage

// File: rtl/aenc_decode.sv
module aenc_decode
    import aenc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DEC_BITS = 29
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NMASK-1:0]  hit_set,
    output logic [NMASK-1:0]  hit_clr,
    output logic              hit_prio
);
    logic [DEC_BITS-1:0] low_addr;
    logic                addr_hi_unused;

    assign low_addr       = addr[DEC_BITS-1:0];
    assign addr_hi_unused = ^addr[ADDR_W-1:DEC_BITS];

    for (genvar r = 0; r < NMASK; r++) begin : g_hit
        assign hit_set[r] = (low_addr == DEC_BITS'(mask_set_addr(r)));
        assign hit_clr[r] = (low_addr == DEC_BITS'(mask_clr_addr(r)));
    end

    assign hit_prio = (low_addr == DEC_BITS'(PRIO_ADDR));
endmodule

// File: rtl/aenc_delta.sv
module aenc_delta
    import aenc_pkg::*;
(
    input  mask_arr_t         old_mask,
    input  mask_arr_t         new_mask,
    input  logic [PRIO_W-1:0] old_prio,
    input  logic [PRIO_W-1:0] new_prio,
    output dlt_arr_t          delta
);
    dlt_arr_t fchg;

    always_comb begin
        int  id;
        logic en_o, en_n;
        fchg = '0;
        for (int r = 0; r < NMASK; r++) begin
            for (int k = 0; k < MASK_W; k++) begin
                id   = mask_src(r, k);
                en_o = old_mask[r][MASK_W-1-k];
                en_n = new_mask[r][MASK_W-1-k];
                if (en_o != en_n)
                    fchg[SRC_W'(id)] = en_n ? fchg[SRC_W'(id)] + 1'b1
                                            : fchg[SRC_W'(id)] - 1'b1;
            end
        end
        for (int k = 0; k < NPFLD; k++) begin
            id   = prio_src(k);
            en_o = |old_prio[PRIO_W-1-k*PFLD_W -: PFLD_W];
            en_n = |new_prio[PRIO_W-1-k*PFLD_W -: PFLD_W];
            if (en_o != en_n)
                fchg[SRC_W'(id)] = en_n ? fchg[SRC_W'(id)] + 1'b1
                                        : fchg[SRC_W'(id)] - 1'b1;
        end
        delta = '0;
        for (int s = 1; s < NSRC; s++)
            if (has_vec(s)) delta[s] = fchg[s];
        // group field change walks down the member chain
        for (int m = 0; m < NGMEM; m++)
            delta[SRC_W'(grp_mem(m))] = delta[SRC_W'(grp_mem(m))] + fchg[GRP_ID];
    end
endmodule

// File: rtl/aenc_pick.sv
module aenc_pick
    import aenc_pkg::*;
#(
    parameter int VEC_W = 12
) (
    input  logic [NSRC-1:0]  pend,
    input  logic [NSRC-1:0]  en,
    output logic             valid,
    output logic [VEC_W-1:0] code
);
    logic pend0_unused;
    assign pend0_unused = pend[0] & en[0];

    always_comb begin
        valid = 1'b0;
        code  = '0;
        for (int s = NSRC - 1; s >= 1; s--) begin
            if (pend[s] && en[s]) begin
                valid = 1'b1;
                code  = VEC_W'(VEC_BASE + VEC_STEP * s);
            end
        end
    end
endmodule

// File: rtl/aenc_ctrl.sv
module aenc_ctrl
    import aenc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 16,
    parameter int VEC_W    = 12,
    parameter int DEC_BITS = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   irq_pend,
    output logic [NSRC-1:0]   src_en,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec_code
);
    st_t               st_q, st_d;
    mask_arr_t         mask_nx;
    logic [PRIO_W-1:0] prio_nx;
    dlt_arr_t          delta;
    logic [NMASK-1:0]  hit_set, hit_clr;
    logic              hit_prio;
    mask_arr_t         mask_q;
    cnt_arr_t          cnt_q;

    aenc_decode #(.ADDR_W(ADDR_W), .DEC_BITS(DEC_BITS)) u_dec (
        .addr(bus_addr), .hit_set(hit_set), .hit_clr(hit_clr), .hit_prio(hit_prio)
    );

    always_comb begin
        mask_nx = st_q.mask;
        prio_nx = st_q.prio;
        if (bus_we) begin
            for (int r = 0; r < NMASK; r++) begin
                if (hit_set[r]) mask_nx[r] = st_q.mask[r] | bus_wdata[MASK_W-1:0];
                if (hit_clr[r]) mask_nx[r] = st_q.mask[r] & ~bus_wdata[MASK_W-1:0];
            end
            if (hit_prio) prio_nx = bus_wdata[PRIO_W-1:0];
        end
    end

    aenc_delta u_delta (
        .old_mask(st_q.mask), .new_mask(mask_nx),
        .old_prio(st_q.prio), .new_prio(prio_nx),
        .delta(delta)
    );

    always_comb begin
        st_d.mask = mask_nx;
        st_d.prio = prio_nx;
        for (int s = 0; s < NSRC; s++)
            st_d.cnt[s] = st_q.cnt[s] + delta[s][CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int s = 0; s < NSRC; s++)
            src_en[s] = has_vec(s) && (src_max(s) != 0) &&
                        (st_q.cnt[s] == CNT_W'(src_max(s)));
    end

    always_comb begin
        bus_rdata = '0;
        for (int r = 0; r < NMASK; r++)
            if (hit_set[r] || hit_clr[r]) bus_rdata = DATA_W'(st_q.mask[r]);
        if (hit_prio) bus_rdata = DATA_W'(st_q.prio);
    end

    aenc_pick #(.VEC_W(VEC_W)) u_pick (
        .pend(irq_pend), .en(src_en), .valid(vec_valid), .code(vec_code)
    );

    assign mask_q = st_q.mask;
    assign cnt_q  = st_q.cnt;
endmodule

// File: rtl/aenc_ctrl_chk.sv
module aenc_ctrl_chk
    import aenc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 16,
    parameter int DEC_BITS = 29
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NSRC-1:0]   irq_pend,
    input logic [NSRC-1:0]   src_en,
    input logic              vec_valid,
    input mask_arr_t         mask_q,
    input cnt_arr_t          cnt_q
);
    for (genvar r = 0; r < NMASK; r++) begin : g_mask
        a_r3_set_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr[DEC_BITS-1:0] == DEC_BITS'(mask_set_addr(r)))
            |=> ((mask_q[r] & $past(bus_wdata[MASK_W-1:0])) == $past(bus_wdata[MASK_W-1:0])));
        a_r4_clr_drops_bits: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr[DEC_BITS-1:0] == DEC_BITS'(mask_clr_addr(r)))
            |=> ((mask_q[r] & $past(bus_wdata[MASK_W-1:0])) == '0));
    end

    for (genvar s = 1; s < NSRC; s++) begin : g_cnt
        if (has_vec(s)) begin : g_v
            a_r7_cnt_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q[s] <= CNT_W'(src_max(s)));
        end
    end

    a_r7_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(src_en));
    a_r10_valid_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ((irq_pend & src_en) != '0));
    a_r10_idle_when_none: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_pend & src_en) == '0) |-> !vec_valid);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (src_en == '0 && !vec_valid));
endmodule

bind aenc_ctrl aenc_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEC_BITS(DEC_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .irq_pend(irq_pend), .src_en(src_en),
    .vec_valid(vec_valid), .mask_q(mask_q), .cnt_q(cnt_q)
);

// File: tb/aenc_ctrl_bench.sv
`timescale 1ns/1ps
module aenc_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] bus_addr;
    logic        bus_we;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [7:0]  irq_pend;
    logic [7:0]  src_en;
    logic        vec_valid;
    logic [11:0] vec_code;

    int checks = 0;
    int fails  = 0;
    logic [3:0]  m0, m1;
    logic [15:0] pr;

    always #2 clk = ~clk;

    aenc_ctrl u_aenc_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pend(irq_pend),
        .src_en(src_en), .vec_valid(vec_valid), .vec_code(vec_code)
    );

    function automatic logic [7:0] exp_en();
        logic [7:0] e;
        e    = '0;
        e[1] = m0[3] && (pr[15:12] != 0);
        e[2] = m0[2];
        e[3] = m0[1];
        e[4] = m1[3] && (pr[11:8] != 0);
        e[5] = m1[2] && (pr[7:4] != 0) && m1[0];
        e[6] = m1[1] && m1[0];
        return e;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 32'h40;
    endtask

    task automatic mset(input int r, input logic [3:0] d, input logic [31:0] hi);
        wr(hi | 32'(r * 8), {12'h0, d});
        if (r == 0) m0 = m0 | d; else m1 = m1 | d;
    endtask

    task automatic mclr(input int r, input logic [3:0] d, input logic [31:0] hi);
        wr(hi | 32'(r * 8 + 4), {12'h0, d});
        if (r == 0) m0 = m0 & ~d; else m1 = m1 & ~d;
    endtask

    task automatic mprio(input logic [15:0] d);
        wr(32'h10, d);
        pr = d;
    endtask

    task automatic rd_chk(input string req, input logic [31:0] a, input logic [15:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic vec_chk(input string req, input logic [7:0] p);
        logic [7:0]  hit;
        logic        ev;
        logic [11:0] ec;
        @(negedge clk);
        irq_pend = p;
        #1;
        hit = p & exp_en();
        ev  = 1'b0; ec = '0;
        for (int s = 7; s >= 1; s--)
            if (hit[s]) begin ev = 1'b1; ec = 12'(12'h400 + 12'h20 * s); end
        chk({req, " valid"}, vec_valid, ev);
        chk({req, " code"}, vec_code, ec);
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] en_before;
        rst_n = 1'b0; bus_addr = 32'h40; bus_we = 1'b0; bus_wdata = '0; irq_pend = 8'hFF;
        m0 = '0; m1 = '0; pr = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        #1;
        chk("R1 src_en in reset", src_en, 8'h00);
        chk("R1 valid in reset", vec_valid, 1'b0);
        rst_n = 1'b1;
        for (int a = 0; a <= 16; a += 4) rd_chk("R1 reg zero", 32'(a), 16'h0);
        vec_chk("R1 vec after reset", 8'hFF);

        // R3/R4: set and clear aliases, readback via both
        mset(0, 4'hA, 0); mset(0, 4'h5, 0);
        rd_chk("R3 set alias read", 32'h00, 16'hF);
        rd_chk("R3 clr alias read", 32'h04, 16'hF);
        mclr(0, 4'h6, 0);
        rd_chk("R4 clear result", 32'h00, 16'h9);
        // R2: high address bits ignored
        mset(1, 4'h4, 32'hE000_0000);
        rd_chk("R2 high bits write", 32'h08, 16'h4);
        rd_chk("R2 high bits read", 32'hA000_000C, 16'h4);
        // R5: direct priority write
        mprio(16'hABCD);
        rd_chk("R5 prio read", 32'h10, 16'hABCD);
        rd_chk("R5 prio aliased read", 32'h2000_0010, 16'hABCD);
        // R11: unmapped addresses
        en_before = src_en;
        wr(32'h14, 16'hFFFF); wr(32'h01, 16'hFFFF); wr(32'h1C, 16'hFFFF);
        rd_chk("R11 unmapped read", 32'h14, 16'h0);
        rd_chk("R11 mask0 kept", 32'h00, 16'h9);
        rd_chk("R11 mask1 kept", 32'h08, 16'h4);
        rd_chk("R11 prio kept", 32'h10, 16'hABCD);
        chk("R11 enables kept", src_en, en_before);

        // R8: reserved fields change nothing
        mset(0, 4'hF, 0); mset(1, 4'hF, 0); mprio(16'h1110);
        chk("R7 all enabled", src_en, 8'h7E);
        mclr(0, 4'h1, 0);
        chk("R8 reserved mask bit", src_en, 8'h7E);
        mprio(16'h111F);
        chk("R8 reserved prio field", src_en, 8'h7E);
        // R9: group bit gates 5 and 6 only
        mclr(1, 4'h1, 0);
        chk("R9 group off", src_en, 8'h1E);
        mset(1, 4'h1, 0);
        chk("R9 group on", src_en, 8'h7E);
        for (int p = 0; p < 256; p++) vec_chk("R10 pend sweep", 8'(p));

        // R10/R7 same cycle: enable update while vector is selected
        mclr(0, 4'hF, 0); mprio(16'h0000); mset(0, 4'h6, 0);
        @(negedge clk);
        irq_pend = 8'h0C;
        bus_addr = 32'h04; bus_wdata = 16'h0004; bus_we = 1'b1;
        #1;
        chk("R10 code before edge", vec_code, 12'h440);
        chk("R7 src2 before edge", src_en[2], 1'b1);
        @(posedge clk);
        #1;
        chk("R10 code after edge", vec_code, 12'h460);
        chk("R7 src2 after edge", src_en[2], 1'b0);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 32'h40;
        m0 = m0 & ~4'h4;

        // R6/R7 sweep over mask pairs and priority patterns
        for (int pm = 0; pm < 8; pm++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    logic [31:0] hi;
                    hi = a[0] ? 32'hE000_0000 : 32'h0;
                    mset(0, 4'(a), hi); mclr(0, ~4'(a), hi);
                    mset(1, 4'(b), 0);  mclr(1, ~4'(b), 0);
                    mprio({pm[0] ? 4'h8 : 4'h0, pm[1] ? 4'h3 : 4'h0,
                           pm[2] ? 4'hF : 4'h0, 4'(pm + b)});
                    chk("R6 R7 sweep src_en", src_en, exp_en());
                    if (b == 0) rd_chk("R3 R4 sweep readback", 32'h04, 16'(a));
                    vec_chk("R10 sweep", 8'(8'hFF << (b % 7)));
                end
            end
        end

        summary();
        $finish;
    end
endmodule